// File: doc/BRIEF.md
# Byte-Serial Word FIFO Data Engine

This block sits between a host that moves 32-bit words and a card data port that moves one byte at a time. A 16-entry word FIFO buffers the data. In the receive direction, bytes arriving from the card are gathered least-significant byte first into words and pushed into the FIFO. In the transmit direction, words are taken from the FIFO and sent to the card one byte at a time, again lowest byte first. A byte counter, loaded from a length register when the data path is switched on, limits the transfer and counts down by one for each byte moved. At most one byte moves per clock.

The host side is a set of strobes: a length write, a control write (enable and direction), a status-read strobe, and a FIFO push and pop. The engine reports the FIFO state as two direction-masked flag groups, a transfer-end indication, the remaining byte count and the remaining word count. It switches itself off once every byte has been moved and the FIFO has drained. After the host pops a word, card-to-FIFO traffic pauses until the host reads status. This suits host software that does not expect the FIFO to change while it is being read.

Top module: `sbfe_engine`

## Requirements
- R1: After a synchronous reset, path_en, byte_cnt, word_cnt, xfer_end, block_end, every flag and both sticky error bits are 0, and host_rdata is 0.
- R2: A control write with ctl_wdata[0]=1 copies the length register into byte_cnt and sets path_en. ctl_wdata[1] picks the direction: 1 is card to FIFO, 0 is FIFO to card. word_cnt always equals (byte_cnt + 3) >> 2.
- R3: When receiving, each byte taken (card_rx_take=1) decrements byte_cnt by one. Four bytes fill a word: the first taken byte goes to bits 7:0, the next to 15:8, then 23:16 and 31:24.
- R4: If byte_cnt reaches zero with fewer than four bytes gathered, the partial word is still pushed, with its unfilled upper bytes zero.
- R5: Receive transfer stalls (card_rx_take=0, byte_cnt held) while the FIFO holds 16 words or card_rdy is 0.
- R6: When transmitting, each FIFO word leaves as four card_tx_valid bytes, bits 7:0 first. Transfer stalls with card_tx_valid=0 while the FIFO is empty and no bytes of a word remain.
- R7: xfer_end and block_end are 1 whenever byte_cnt is zero after the data path has been enabled at least once.
- R8: One cycle after byte_cnt and the FIFO are both empty, path_en clears and every FIFO flag reads 0.
- R9: While path_en is 1, only the group for the current direction is shown. Within it, active is 1, empty is set at fill 0, avail at nonzero fill and full at fill 16. tx_half_empty is set at fill of 8 or less, and rx_half_full at fill of 8 or more.
- R10: After a host pop, no card byte is taken until the next cycle after stat_rd is pulsed.
- R11: A pop from an empty FIFO returns 0 on host_rdata and sets udf_err. A push while byte_cnt is zero is ignored.
- R12: A host push into a full FIFO is dropped and sets ovf_err. The 16 stored words and their order are kept.
- R13: An engine word push and a host pop in the same cycle both take effect, so the fill level is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| len_we | input | 1 | Write strobe for the length register |
| len_wdata | input | 16 | Transfer length in bytes |
| ctl_we | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 2 | Bit 0 enable, bit 1 direction (1 = card to FIFO) |
| stat_rd | input | 1 | Host read of status or word count; ends the refill hold-off |
| host_push | input | 1 | Host pushes host_wdata into the FIFO |
| host_wdata | input | 32 | Word to push |
| host_pop | input | 1 | Host pops the head word |
| host_rdata | output | 32 | Head word, or 0 when the FIFO is empty |
| card_rdy | input | 1 | Card has a receive byte available |
| card_rx_byte | input | 8 | Receive byte from the card |
| card_rx_take | output | 1 | Receive byte consumed this cycle |
| card_tx_byte | output | 8 | Transmit byte to the card |
| card_tx_valid | output | 1 | Transmit byte valid this cycle |
| path_en | output | 1 | Data path enabled |
| path_dir | output | 1 | Current direction (1 = card to FIFO) |
| byte_cnt | output | 16 | Bytes left to move |
| word_cnt | output | 16 | Words left, rounded up |
| xfer_end | output | 1 | Transfer complete |
| block_end | output | 1 | Block complete |
| tx_active | output | 1 | Transmit group: engine active |
| tx_half_empty | output | 1 | Transmit group: fill at most 8 |
| tx_full | output | 1 | Transmit group: fill 16 |
| tx_empty | output | 1 | Transmit group: fill 0 |
| tx_avail | output | 1 | Transmit group: fill nonzero |
| rx_active | output | 1 | Receive group: engine active |
| rx_half_full | output | 1 | Receive group: fill at least 8 |
| rx_full | output | 1 | Receive group: fill 16 |
| rx_empty | output | 1 | Receive group: fill 0 |
| rx_avail | output | 1 | Receive group: fill nonzero |
| ovf_err | output | 1 | Sticky: host push hit a full FIFO |
| udf_err | output | 1 | Sticky: host pop hit an empty FIFO |

## Verification
The engine pushing a completed receive word and the host popping the head word can land in the same clock. The bench provokes this with the FIFO one word short of full. It releases the hold-off and raises host_pop on exactly the cycle the fourth byte of a word is taken. The result is judged three ways: the popped word must be the correct one, the full flag must stay low that cycle, and it must rise once one more word has been gathered. Draining all the words in the expected order then shows that neither the pushed word nor the pop was lost.

// File: rtl/sbfe_pkg.sv
`timescale 1ns/1ps
package sbfe_pkg;
   typedef enum logic {
      DIR_TX = 1'b0,
      DIR_RX = 1'b1
   } sbfe_dir_e;
endpackage

// File: rtl/sbfe_word_fifo.sv
`timescale 1ns/1ps
module sbfe_word_fifo #(
   parameter int DEPTH = 16,
   parameter int WIDTH = 32
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       wr_en,
   input  logic [WIDTH-1:0]           wr_data,
   input  logic                       rd_en,
   output logic [WIDTH-1:0]           head,
   output logic [$clog2(DEPTH):0]     fill
);
   localparam int PTR_W  = $clog2(DEPTH);
   localparam int FILL_W = PTR_W + 1;

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wp, rp;
   logic             full, empty, wr_ok, rd_ok;

   assign full  = (fill == FILL_W'(DEPTH));
   assign empty = (fill == '0);
   assign wr_ok = wr_en && !full;
   assign rd_ok = rd_en && !empty;
   assign head  = mem[rp];

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (wr_ok && (wp == PTR_W'(i))) mem[i] <= wr_data;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wp   <= '0;
         rp   <= '0;
         fill <= '0;
      end else begin
         if (wr_ok) wp <= wp + PTR_W'(1);
         if (rd_ok) rp <= rp + PTR_W'(1);
         case ({wr_ok, rd_ok})
            2'b10:   fill <= fill + FILL_W'(1);
            2'b01:   fill <= fill - FILL_W'(1);
            default: fill <= fill;
         endcase
      end
   end

   assert_fill_bound_R12: assert property (@(posedge clk) disable iff (rst)
      fill <= FILL_W'(DEPTH));
   assert_full_drop_R12: assert property (@(posedge clk) disable iff (rst)
      (full && wr_en && !rd_en) |=> (fill == FILL_W'(DEPTH)) && $stable(wp));
endmodule

// File: rtl/sbfe_mover.sv
`timescale 1ns/1ps
module sbfe_mover
   import sbfe_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int BYTES = 4,
   parameter int LEN_W = 16
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       ctl_we,
   input  logic                       ctl_en_bit,
   input  logic                       ctl_dir_bit,
   input  logic [LEN_W-1:0]           len_val,
   input  logic [$clog2(DEPTH):0]     fill,
   input  logic [8*BYTES-1:0]         head,
   input  logic                       card_rdy,
   input  logic [7:0]                 card_byte,
   input  logic                       hold,
   output logic                       en,
   output sbfe_dir_e                  dir,
   output logic [LEN_W-1:0]           count,
   output logic                       started,
   output logic                       push,
   output logic [8*BYTES-1:0]         push_word,
   output logic                       pop,
   output logic [7:0]                 tx_byte,
   output logic                       tx_valid,
   output logic                       rx_take
);
   localparam int WORD_W = 8 * BYTES;
   localparam int LANE_W = $clog2(BYTES);
   localparam int FILL_W = $clog2(DEPTH) + 1;

   logic [WORD_W-1:0] acc_w, unpk;
   logic [LANE_W-1:0] pack_n, unpk_n;
   logic              active, last_byte, rx_go, tx_go, pack_done;

   assign active    = en && !ctl_we;
   assign last_byte = (count == LEN_W'(1));
   assign rx_go     = active && (dir == DIR_RX) && (count != '0) && !hold
                      && card_rdy && (fill != FILL_W'(DEPTH));
   assign tx_go     = active && (dir == DIR_TX) && (count != '0)
                      && ((unpk_n != '0) || (fill != '0));
   assign pack_done = rx_go && ((pack_n == LANE_W'(BYTES-1)) || last_byte);

   assign rx_take  = rx_go;
   assign push     = pack_done;
   assign tx_valid = tx_go;
   assign pop      = tx_go && (unpk_n == '0);
   assign tx_byte  = (unpk_n == '0) ? head[7:0] : unpk[7:0];

   for (genvar k = 0; k < BYTES; k++) begin : g_lane
      assign push_word[8*k +: 8] = (LANE_W'(k) < pack_n)  ? acc_w[8*k +: 8] :
                                   (LANE_W'(k) == pack_n) ? card_byte : 8'h00;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         en      <= 1'b0;
         dir     <= DIR_TX;
         count   <= '0;
         started <= 1'b0;
         pack_n  <= '0;
         acc_w   <= '0;
         unpk    <= '0;
         unpk_n  <= '0;
      end else if (ctl_we) begin
         en  <= ctl_en_bit;
         dir <= sbfe_dir_e'(ctl_dir_bit);
         if (ctl_en_bit) begin
            count   <= len_val;
            started <= 1'b1;
            pack_n  <= '0;
            unpk_n  <= '0;
         end
      end else begin
         if (en && (count == '0) && (fill == '0)) en <= 1'b0;
         if (rx_go || tx_go) count <= count - LEN_W'(1);
         if (rx_go) begin
            for (int k = 0; k < BYTES; k++) begin
               if (pack_n == LANE_W'(k)) acc_w[8*k +: 8] <= card_byte;
            end
            pack_n <= pack_done ? '0 : pack_n + LANE_W'(1);
         end
         if (tx_go) begin
            if (unpk_n == '0) begin
               unpk   <= head >> 8;
               unpk_n <= LANE_W'(BYTES-1);
            end else begin
               unpk   <= unpk >> 8;
               unpk_n <= unpk_n - LANE_W'(1);
            end
            if (last_byte) unpk_n <= '0;
         end
      end
   end

   assert_full_stall_R5: assert property (@(posedge clk) disable iff (rst)
      (fill == FILL_W'(DEPTH)) |-> !rx_take);
   assert_autodis_R8: assert property (@(posedge clk) disable iff (rst)
      (en && (count == '0) && (fill == '0) && !ctl_we) |=> !en);
   assert_count_down_R3: assert property (@(posedge clk) disable iff (rst)
      !(ctl_we && ctl_en_bit) |=> (count <= $past(count)));
endmodule

// File: rtl/sbfe_flags.sv
`timescale 1ns/1ps
module sbfe_flags
   import sbfe_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int LEN_W = 16
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       en,
   input  sbfe_dir_e                  dir,
   input  logic [$clog2(DEPTH):0]     fill,
   input  logic [LEN_W-1:0]           count,
   input  logic                       started,
   output logic                       xfer_end,
   output logic                       block_end,
   output logic                       tx_active,
   output logic                       tx_half_empty,
   output logic                       tx_full,
   output logic                       tx_empty,
   output logic                       tx_avail,
   output logic                       rx_active,
   output logic                       rx_half_full,
   output logic                       rx_full,
   output logic                       rx_empty,
   output logic                       rx_avail
);
   localparam int FILL_W = $clog2(DEPTH) + 1;
   localparam int HALF   = DEPTH / 2;

   logic tx_on, rx_on, f_empty, f_full;

   assign tx_on   = en && (dir == DIR_TX);
   assign rx_on   = en && (dir == DIR_RX);
   assign f_empty = (fill == '0);
   assign f_full  = (fill == FILL_W'(DEPTH));

   assign xfer_end  = started && (count == '0);
   assign block_end = started && (count == '0);

   assign tx_active     = tx_on;
   assign tx_half_empty = tx_on && (fill <= FILL_W'(HALF));
   assign tx_full       = tx_on && f_full;
   assign tx_empty      = tx_on && f_empty;
   assign tx_avail      = tx_on && !f_empty;

   assign rx_active    = rx_on;
   assign rx_half_full = rx_on && (fill >= FILL_W'(HALF));
   assign rx_full      = rx_on && f_full;
   assign rx_empty     = rx_on && f_empty;
   assign rx_avail     = rx_on && !f_empty;

   assert_dir_mask_R9: assert property (@(posedge clk) disable iff (rst)
      $onehot0({tx_active, rx_active}) && $onehot0({tx_avail, rx_avail}));
endmodule

// File: rtl/sbfe_engine.sv
`timescale 1ns/1ps
module sbfe_engine
   import sbfe_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int BYTES = 4,
   parameter int LEN_W = 16
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 len_we,
   input  logic [LEN_W-1:0]     len_wdata,
   input  logic                 ctl_we,
   input  logic [1:0]           ctl_wdata,
   input  logic                 stat_rd,
   input  logic                 host_push,
   input  logic [8*BYTES-1:0]   host_wdata,
   input  logic                 host_pop,
   output logic [8*BYTES-1:0]   host_rdata,
   input  logic                 card_rdy,
   input  logic [7:0]           card_rx_byte,
   output logic                 card_rx_take,
   output logic [7:0]           card_tx_byte,
   output logic                 card_tx_valid,
   output logic                 path_en,
   output logic                 path_dir,
   output logic [LEN_W-1:0]     byte_cnt,
   output logic [LEN_W-1:0]     word_cnt,
   output logic                 xfer_end,
   output logic                 block_end,
   output logic                 tx_active,
   output logic                 tx_half_empty,
   output logic                 tx_full,
   output logic                 tx_empty,
   output logic                 tx_avail,
   output logic                 rx_active,
   output logic                 rx_half_full,
   output logic                 rx_full,
   output logic                 rx_empty,
   output logic                 rx_avail,
   output logic                 ovf_err,
   output logic                 udf_err
);
   localparam int WORD_W = 8 * BYTES;
   localparam int LANE_W = $clog2(BYTES);
   localparam int FILL_W = $clog2(DEPTH) + 1;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (BYTES < 2 || (BYTES & (BYTES - 1)) != 0) begin : g_bad_bytes
      $error("BYTES must be a power of two of at least 2");
   end
   if (LEN_W < 2) begin : g_bad_len
      $error("LEN_W must be at least 2");
   end

   logic [LEN_W-1:0]  len_reg;
   logic [FILL_W-1:0] fill;
   logic [WORD_W-1:0] head, eng_word;
   logic              eng_push, eng_pop, hold, started;
   logic              rx_busy, tx_busy, f_full, f_empty;
   logic              push_ok, pop_ok;
   sbfe_dir_e         dir;

   assign f_full   = (fill == FILL_W'(DEPTH));
   assign f_empty  = (fill == '0);
   assign rx_busy  = path_en && (dir == DIR_RX);
   assign tx_busy  = path_en && (dir == DIR_TX);
   assign push_ok  = host_push && (byte_cnt != '0) && !rx_busy && !f_full;
   assign pop_ok   = host_pop && !f_empty && !tx_busy;
   assign path_dir = (dir == DIR_RX);
   assign host_rdata = f_empty ? '0 : head;
   assign word_cnt = LEN_W'(({1'b0, byte_cnt} + (LEN_W+1)'(BYTES-1)) >> LANE_W);

   always_ff @(posedge clk) begin
      if (rst) begin
         len_reg <= '0;
         hold    <= 1'b0;
         ovf_err <= 1'b0;
         udf_err <= 1'b0;
      end else begin
         if (len_we) len_reg <= len_wdata;
         if (pop_ok) hold <= 1'b1;
         else if (stat_rd) hold <= 1'b0;
         if (host_push && (byte_cnt != '0) && !rx_busy && f_full) ovf_err <= 1'b1;
         if (host_pop && f_empty) udf_err <= 1'b1;
      end
   end

   sbfe_word_fifo #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_fifo (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (eng_push || push_ok),
      .wr_data (eng_push ? eng_word : host_wdata),
      .rd_en   (eng_pop || pop_ok),
      .head    (head),
      .fill    (fill)
   );

   sbfe_mover #(.DEPTH(DEPTH), .BYTES(BYTES), .LEN_W(LEN_W)) u_mover (
      .clk         (clk),
      .rst         (rst),
      .ctl_we      (ctl_we),
      .ctl_en_bit  (ctl_wdata[0]),
      .ctl_dir_bit (ctl_wdata[1]),
      .len_val     (len_reg),
      .fill        (fill),
      .head        (head),
      .card_rdy    (card_rdy),
      .card_byte   (card_rx_byte),
      .hold        (hold),
      .en          (path_en),
      .dir         (dir),
      .count       (byte_cnt),
      .started     (started),
      .push        (eng_push),
      .push_word   (eng_word),
      .pop         (eng_pop),
      .tx_byte     (card_tx_byte),
      .tx_valid    (card_tx_valid),
      .rx_take     (card_rx_take)
   );

   sbfe_flags #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_flags (
      .clk           (clk),
      .rst           (rst),
      .en            (path_en),
      .dir           (dir),
      .fill          (fill),
      .count         (byte_cnt),
      .started       (started),
      .xfer_end      (xfer_end),
      .block_end     (block_end),
      .tx_active     (tx_active),
      .tx_half_empty (tx_half_empty),
      .tx_full       (tx_full),
      .tx_empty      (tx_empty),
      .tx_avail      (tx_avail),
      .rx_active     (rx_active),
      .rx_half_full  (rx_half_full),
      .rx_full       (rx_full),
      .rx_empty      (rx_empty),
      .rx_avail      (rx_avail)
   );

   assert_holdoff_R10: assert property (@(posedge clk) disable iff (rst)
      hold |-> !card_rx_take);
   assert_pop_empty_R11: assert property (@(posedge clk) disable iff (rst)
      (host_pop && f_empty) |=> udf_err);
   assert_push_full_R12: assert property (@(posedge clk) disable iff (rst)
      (host_push && f_full && !path_en) |=> (fill == FILL_W'(DEPTH)) && ovf_err);
   assert_collide_R13: assert property (@(posedge clk) disable iff (rst)
      (eng_push && pop_ok) |=> (fill == $past(fill)));
endmodule

// File: tb/sbfe_engine_tb.sv
`timescale 1ns/1ps
module sbfe_engine_tb;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        len_we = 0, ctl_we = 0, stat_rd = 0, host_push = 0, host_pop = 0, card_rdy = 0;
   logic [15:0] len_wdata = '0;
   logic [1:0]  ctl_wdata = '0;
   logic [31:0] host_wdata = '0;
   logic [7:0]  card_rx_byte = '0;
   logic [31:0] host_rdata;
   logic        card_rx_take, card_tx_valid, path_en, path_dir;
   logic [7:0]  card_tx_byte;
   logic [15:0] byte_cnt, word_cnt;
   logic        xfer_end, block_end, tx_active, tx_half_empty, tx_full, tx_empty, tx_avail;
   logic        rx_active, rx_half_full, rx_full, rx_empty, rx_avail, ovf_err, udf_err;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #2 clk = ~clk;

   sbfe_engine u_dut (
      .clk(clk), .rst(rst), .len_we(len_we), .len_wdata(len_wdata),
      .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .stat_rd(stat_rd),
      .host_push(host_push), .host_wdata(host_wdata), .host_pop(host_pop),
      .host_rdata(host_rdata), .card_rdy(card_rdy), .card_rx_byte(card_rx_byte),
      .card_rx_take(card_rx_take), .card_tx_byte(card_tx_byte),
      .card_tx_valid(card_tx_valid), .path_en(path_en), .path_dir(path_dir),
      .byte_cnt(byte_cnt), .word_cnt(word_cnt), .xfer_end(xfer_end),
      .block_end(block_end), .tx_active(tx_active), .tx_half_empty(tx_half_empty),
      .tx_full(tx_full), .tx_empty(tx_empty), .tx_avail(tx_avail),
      .rx_active(rx_active), .rx_half_full(rx_half_full), .rx_full(rx_full),
      .rx_empty(rx_empty), .rx_avail(rx_avail), .ovf_err(ovf_err), .udf_err(udf_err)
   );

   localparam int NV = 6;
   localparam logic [15:0] LEN_T  [NV] = '{16'd1, 16'd3, 16'd4, 16'd5, 16'd8, 16'd13};
   localparam logic [7:0]  SEED_T [NV] = '{8'h10, 8'hA0, 8'h3C, 8'hFE, 8'h01, 8'h55};

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   function automatic logic [31:0] rx_word(input logic [7:0] seed, input int w, input int len);
      logic [31:0] r = '0;
      for (int b = 0; b < 4; b++)
         if (w*4 + b < len) r[8*b +: 8] = 8'(seed + 8'(w*4 + b));
      return r;
   endfunction

   task automatic load_and_enable(input logic [15:0] len, input logic [1:0] ctl);
      len_we = 1; len_wdata = len; step(); len_we = 0;
      ctl_we = 1; ctl_wdata = ctl; step(); ctl_we = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog R1 actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int idx;
      int guard;
      logic [7:0] seed;
      int len;
      repeat (3) @(posedge clk);
      #1 rst = 0;
      step();
      // reset state
      chk("R1 path_en", 32'(path_en), 0);
      chk("R1 byte_cnt", 32'(byte_cnt), 0);
      chk("R1 word_cnt", 32'(word_cnt), 0);
      chk("R1 xfer_end", 32'({xfer_end, block_end}), 0);
      chk("R1 flags", 32'({tx_active, tx_half_empty, tx_full, tx_empty, tx_avail,
                           rx_active, rx_half_full, rx_full, rx_empty, rx_avail}), 0);
      chk("R1 errs", 32'({ovf_err, udf_err}), 0);
      chk("R1 rdata", host_rdata, 0);

      // table of receive transfers
      for (int v = 0; v < NV; v++) begin
         len = int'(LEN_T[v]);
         seed = SEED_T[v];
         load_and_enable(LEN_T[v], 2'b11);
         chk("R2 byte_cnt load", 32'(byte_cnt), 32'(len));
         chk("R2 word_cnt", 32'(word_cnt), 32'((len + 3) >> 2));
         chk("R2 dir/en", 32'({path_en, path_dir}), 2'b11);
         card_rdy = 1; idx = 0; guard = 0;
         while (byte_cnt != 0 && guard < 100) begin
            card_rx_byte = 8'(seed + 8'(idx));
            #1;
            if (card_rx_take) idx++;
            @(posedge clk); #1;
            guard++;
         end
         card_rdy = 0;
         chk("R3 bytes taken", 32'(idx), 32'(len));
         chk("R7 xfer_end", 32'({xfer_end, block_end}), 2'b11);
         chk("R9 rx group only", 32'({rx_avail, rx_active, tx_active, tx_avail}), 4'b1100);
         for (int w = 0; w < (len + 3) / 4; w++) begin
            host_pop = 1; #1;
            chk((w*4 + 4 > len) ? "R4 short word" : "R3 packed word", host_rdata, rx_word(seed, w, len));
            step(); host_pop = 0;
            stat_rd = 1; step(); stat_rd = 0;
         end
         chk("R8 auto disable", 32'({path_en, rx_active, rx_empty}), 0);
      end

      // receive stall, full, hold-off and same-cycle push/pop
      seed = 8'h20;
      load_and_enable(16'd72, 2'b11);
      card_rdy = 0; #1;
      chk("R5 not ready no take", 32'(card_rx_take), 0);
      step();
      chk("R5 not ready cnt held", 32'(byte_cnt), 72);
      card_rdy = 1; idx = 0; guard = 0;
      while (idx < 64 && guard < 200) begin
         card_rx_byte = 8'(seed + 8'(idx));
         #1;
         if (card_rx_take) idx++;
         @(posedge clk); #1;
         guard++;
      end
      chk("R9 rx full flags", 32'({rx_full, rx_half_full, rx_empty, rx_avail}), 4'b1101);
      chk("R5 cnt at full", 32'(byte_cnt), 8);
      card_rx_byte = 8'(seed + 8'(idx)); #1;
      chk("R5 full no take", 32'(card_rx_take), 0);
      step();
      host_pop = 1; #1;
      chk("R3 word0", host_rdata, rx_word(seed, 0, 72));
      step(); host_pop = 0;
      chk("R9 not full after pop", 32'(rx_full), 0);
      for (int c = 0; c < 3; c++) begin
         #1;
         chk("R10 hold no take", 32'(card_rx_take), 0);
         step();
      end
      chk("R10 cnt held", 32'(byte_cnt), 8);
      stat_rd = 1; #1;
      chk("R10 hold until stat edge", 32'(card_rx_take), 0);
      step(); stat_rd = 0;
      for (int k = 0; k < 4; k++) begin
         card_rx_byte = 8'(seed + 8'(idx));
         host_pop = (k == 3);
         #1;
         chk("R10 resumed take", 32'(card_rx_take), 1);
         if (k == 3) chk("R13 popped word1", host_rdata, rx_word(seed, 1, 72));
         if (card_rx_take) idx++;
         step(); host_pop = 0;
      end
      chk("R13 fill unchanged", 32'(rx_full), 0);
      stat_rd = 1; step(); stat_rd = 0;
      guard = 0;
      while (byte_cnt != 0 && guard < 50) begin
         card_rx_byte = 8'(seed + 8'(idx));
         #1;
         if (card_rx_take) idx++;
         @(posedge clk); #1;
         guard++;
      end
      card_rdy = 0;
      chk("R13 full after last word", 32'(rx_full), 1);
      chk("R7 end flags", 32'({xfer_end, block_end}), 2'b11);
      for (int w = 2; w < 18; w++) begin
         host_pop = 1; #1;
         chk("R13 drain order", host_rdata, rx_word(seed, w, 72));
         step(); host_pop = 0;
      end
      host_pop = 1; #1;
      chk("R11 empty pop zero", host_rdata, 0);
      step(); host_pop = 0;
      chk("R11 udf sticky", 32'(udf_err), 1);
      chk("R8 disabled and flags clear", 32'({path_en, rx_active, rx_empty, rx_avail}), 0);

      // transmit unpacking
      load_and_enable(16'd6, 2'b01);
      chk("R9 tx group", 32'({tx_active, tx_empty, tx_half_empty, tx_avail, rx_active, rx_empty}), 6'b111000);
      #1;
      chk("R6 empty stall", 32'(card_tx_valid), 0);
      step();
      chk("R6 cnt held", 32'(byte_cnt), 6);
      host_push = 1; host_wdata = 32'h4433_2211; #1;
      chk("R6 no byte on push cycle", 32'(card_tx_valid), 0);
      step(); host_push = 0;
      for (int k = 0; k < 4; k++) begin
         #1;
         chk("R6 tx byte", 32'({card_tx_valid, card_tx_byte}), 32'({1'b1, 8'(8'h11 * (k + 1))}));
         step();
      end
      #1;
      chk("R6 stall between words", 32'(card_tx_valid), 0);
      step();
      chk("R6 cnt after word", 32'(byte_cnt), 2);
      host_push = 1; host_wdata = 32'h8877_6655; step(); host_push = 0;
      for (int k = 0; k < 2; k++) begin
         #1;
         chk("R6 tx tail byte", 32'({card_tx_valid, card_tx_byte}), 32'({1'b1, 8'(8'h55 + 8'(k * 8'h11))}));
         step();
      end
      chk("R7 tx end", 32'({xfer_end, block_end, path_en}), 3'b111);
      step();
      chk("R8 tx auto disable", 32'({path_en, tx_active, tx_empty}), 0);
      host_push = 1; host_wdata = 32'hDEAD_BEEF; step(); host_push = 0;
      #1;
      chk("R11 push at zero count ignored", host_rdata, 0);

      // overflow with engine stopped
      load_and_enable(16'd100, 2'b01);
      ctl_we = 1; ctl_wdata = 2'b00; step(); ctl_we = 0;
      chk("R2 stop keeps count", 32'({path_en, byte_cnt}), 32'({1'b0, 16'd100}));
      for (int i = 0; i < 17; i++) begin
         host_push = 1; host_wdata = 32'hC000_0000 + 32'(i);
         step();
         if (i == 15) chk("R12 no ovf at 16", 32'(ovf_err), 0);
      end
      host_push = 0;
      chk("R12 ovf sticky", 32'(ovf_err), 1);
      for (int i = 0; i < 16; i++) begin
         host_pop = 1; #1;
         chk("R12 contents intact", host_rdata, 32'hC000_0000 + 32'(i));
         step(); host_pop = 0;
      end
      #1;
      chk("R12 dropped word absent", host_rdata, 0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule